// File: doc/BRIEF.md
# Program-Memory Download Port with Readback

This block lets a host load and check the instruction memory of a small embedded controller through one 32-bit register. Each word written holds a command code in bits 31:24, a data byte in bits 23:16 and an address field in bits 15:0. The upload code stores the data byte into the program RAM. Every host read returns the command code now in force, the byte at the internal pointer and the pointer itself. In upload mode the read then moves the pointer forward by one. The same register therefore serves to store bytes, to confirm each store at once, and to walk back through the whole image to verify it.

The host can only supply the low eight address bits. The bits above them are taken from the shared pointer, which reads move forward. A host that stores bytes in order and confirms each one with a read crosses every 256-byte page without further action. The command codes keep the controller in reset while loading (0x0F), close the load (0x03) and start the controller (0x13). While the controller runs, a second read-only port serves its instruction fetches.

The RAM depth is set by `ADDR_W`. The full part uses 14 bits (16K bytes). The default is 12 bits, which keeps a plain elaboration small.

Top module: `fw_load_port`

## Requirements
- R1: After reset the controller is held (`cpu_hold` = 1), the held command code is 0x00, the pointer is 0 and `reg_rdata` is 0.
- R2: A write whose bits 31:24 are 0x0F enters upload mode and holds the controller. Every later host read returns 0x0F in bits 31:24 until another code is written.
- R3: In a write carrying code 0x0F, the data byte (bits 23:16) is stored at effective address {pointer[ADDR_W-1:8], wdata[7:0]}, and the pointer takes that address. Bits 15:8 of the written word have no effect.
- R4: A host read (`reg_rd` without `reg_wr`) shows {code, RAM[pointer], zero padding, pointer} on `reg_rdata` from the next cycle on. In upload mode the pointer then advances by one and wraps from 2^ADDR_W-1 to 0.
- R5: A read issued straight after an upload write whose address field is below 256 and within the current page returns exactly the written word.
- R6: After code 0x03 the controller stays held, writes store nothing and change no pointer bit, and reads leave the pointer unchanged.
- R7: `cpu_hold` is low exactly while the last written code is 0x13. Any other code holds the controller.
- R8: While running, `fetch_data` shows RAM[`fetch_addr`] one cycle after the address is applied. Whenever the controller was held in the previous cycle, `fetch_data` is 0.
- R9: When `reg_wr` and `reg_rd` are high in the same cycle, the write is carried out and the read is dropped, so `reg_rdata` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_rd | input | 1 | Register read strobe, one cycle |
| reg_wdata | input | 32 | Write word {code, data, address field} |
| reg_rdata | output | 32 | Read word {code, byte at pointer, padding, pointer} |
| cpu_hold | output | 1 | Holds the controller in reset when 1 |
| fetch_addr | input | ADDR_W | Instruction fetch address from the controller |
| fetch_data | output | 8 | Fetched instruction byte, one cycle latency |

## Verification
The hardest case to reach from the ports is a store whose upper address bits come from the pointer rather than from the host. The upper bits only move when reads step the pointer. The stimulus fills the whole RAM with alternating write and confirm-read pairs, so the pointer crosses every page boundary and finally wraps to zero. It then writes an address field with upper bits set and checks that the store landed in the pointer's page. To show that stores made after the close code are dropped, the bench starts the controller and reads that location back through the fetch port.

// File: rtl/fwl_pkg.sv
// Shared codes and word layout for the program-memory download port.
// Assumes a 32-bit host register with a 16-bit address field.
package fwl_pkg;
    localparam logic [7:0] CODE_UPLOAD = 8'h0F;
    localparam logic [7:0] CODE_CLOSE  = 8'h03;
    localparam logic [7:0] CODE_RUN    = 8'h13;

    typedef struct packed {
        logic [7:0]  code;
        logic [7:0]  data;
        logic [15:0] addr;
    } dl_word_t;
endpackage

// File: rtl/fwl_decode.sv
// Holds the last written command code and decodes the strobes into RAM,
// pointer and read-capture enables. Assumes strobes last one cycle.
module fwl_decode
    import fwl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] code_in,
    output logic [7:0] code_q,
    output logic       upload,
    output logic       cpu_hold,
    output logic       ram_we,
    output logic       host_rd,
    output logic       ptr_step
);
    // Capture the command code on every host write.
    always_ff @(posedge clk) begin
        if (!rst_n)      code_q <= 8'h00;
        else if (reg_wr) code_q <= code_in;
    end

    // Derive modes and enables; a write wins over a read in the same cycle.
    always_comb begin
        upload   = (code_q == CODE_UPLOAD);
        cpu_hold = (code_q != CODE_RUN);
        ram_we   = reg_wr && (code_in == CODE_UPLOAD);
        host_rd  = reg_rd && !reg_wr;
        ptr_step = host_rd && upload;
    end
endmodule

// File: rtl/fwl_pointer.sv
// Shared address pointer. An upload write loads it with the host's low byte
// and keeps its own upper bits; an upload read advances it with wrap.
// Assumes ADDR_W is between 9 and 15.
module fwl_pointer #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [7:0]        low_byte,
    output logic [ADDR_W-1:0] ptr_q,
    output logic [ADDR_W-1:0] eff_addr
);
    localparam int HI_W = ADDR_W - 8;

    // Effective write address: pointer page plus host low byte.
    generate
        if (HI_W > 0) begin : g_paged
            assign eff_addr = {ptr_q[ADDR_W-1:8], low_byte};
        end else begin : g_flat
            assign eff_addr = low_byte[ADDR_W-1:0];
        end
    endgenerate

    // Update the pointer on upload writes and upload reads.
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr_q <= '0;
        else if (load) ptr_q <= eff_addr;
        else if (step) ptr_q <= ptr_q + 1'b1;
    end
endmodule

// File: rtl/fwl_ram.sv
// Program RAM, one byte wide: one write port, one enabled host read port,
// and a fetch read port that returns zero while the controller is held.
// Assumes host reads never hit the write address in the same cycle.
module fwl_ram #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic              host_en,
    input  logic [ADDR_W-1:0] host_addr,
    output logic [7:0]        host_q,
    input  logic              run,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [7:0]        fetch_q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    // Store host bytes.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Host readback byte, captured only on a read.
    always_ff @(posedge clk) begin
        if (!rst_n)       host_q <= 8'h00;
        else if (host_en) host_q <= mem[host_addr];
    end

    // Instruction fetch, forced to zero while held.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) fetch_q <= 8'h00;
        else                fetch_q <= mem[fetch_addr];
    end
endmodule

// File: rtl/fw_load_port.sv
// Top of the program-memory download port. Joins decode, pointer and RAM
// and forms the readback word. Assumes 9 <= ADDR_W <= 15.
module fw_load_port
    import fwl_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              cpu_hold,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [7:0]        fetch_data
);
    localparam int PAD_W = 16 - ADDR_W;

    dl_word_t          wword;
    logic [7:0]        code_q;
    logic              upload, ram_we, host_rd, ptr_step;
    logic [ADDR_W-1:0] ptr_q, eff_addr, rd_ptr_q;
    logic [7:0]        rd_code_q, host_q;

    assign wword = dl_word_t'(reg_wdata);

    fwl_decode u_decode (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .code_in(wword.code), .code_q(code_q), .upload(upload),
        .cpu_hold(cpu_hold), .ram_we(ram_we), .host_rd(host_rd),
        .ptr_step(ptr_step)
    );

    fwl_pointer #(.ADDR_W(ADDR_W)) u_pointer (
        .clk(clk), .rst_n(rst_n), .load(ram_we), .step(ptr_step),
        .low_byte(wword.addr[7:0]), .ptr_q(ptr_q), .eff_addr(eff_addr)
    );

    fwl_ram #(.ADDR_W(ADDR_W)) u_ram (
        .clk(clk), .rst_n(rst_n), .we(ram_we), .waddr(eff_addr),
        .wdata(wword.data), .host_en(host_rd), .host_addr(ptr_q),
        .host_q(host_q), .run(!cpu_hold), .fetch_addr(fetch_addr),
        .fetch_q(fetch_data)
    );

    // Capture code and pointer alongside the RAM byte on each host read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_code_q <= 8'h00;
            rd_ptr_q  <= '0;
        end else if (host_rd) begin
            rd_code_q <= code_q;
            rd_ptr_q  <= ptr_q;
        end
    end

    // Assemble the readback word with zero padding above the pointer.
    assign reg_rdata = {rd_code_q, host_q, {PAD_W{1'b0}}, rd_ptr_q};
endmodule

// File: rtl/fwl_checker.sv
// Property checker for fw_load_port, attached with bind.
module fwl_checker #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic              cpu_hold,
    input logic              upload,
    input logic [ADDR_W-1:0] ptr_q,
    input logic [7:0]        fetch_data
);
    a_r2_upload_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[31:24] == 8'h0F) |=> (cpu_hold && upload));

    a_r3_page_from_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[31:24] == 8'h0F) |=>
        (ptr_q[ADDR_W-1:8] == $past(ptr_q[ADDR_W-1:8]) &&
         ptr_q[7:0] == $past(reg_wdata[7:0])));

    a_r4_step_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && upload) |=> (ptr_q == $past(ptr_q) + 1'b1));

    a_r6_ptr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!upload && !(reg_wr && reg_wdata[31:24] == 8'h0F)) |=> $stable(ptr_q));

    a_r7_run_code: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[31:24] == 8'h13) |=> !cpu_hold);

    a_r8_fetch_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hold |=> (fetch_data == 8'h00));

    a_r9_read_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_rd) |=> $stable(reg_rdata));
endmodule

bind fw_load_port fwl_checker #(.ADDR_W(ADDR_W)) u_fwl_checker (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_hold(cpu_hold),
    .upload(upload), .ptr_q(ptr_q), .fetch_data(fetch_data)
);

// File: tb/test_fw_load_port.sv
module test_fw_load_port;
    localparam int AW    = 12;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          cpu_hold;
    logic [AW-1:0] fetch_addr = '0;
    logic [7:0]    fetch_data;

    int checks = 0;
    int errors = 0;

    logic [7:0]    m_mem [DEPTH];
    logic [7:0]    m_code = 8'h00;
    logic [AW-1:0] m_ptr = '0;

    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        rd_seen = 1'b0;

    always #2 clk = ~clk;

    fw_load_port #(.ADDR_W(AW)) i_fw_load_port (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_hold(cpu_hold),
        .fetch_addr(fetch_addr), .fetch_data(fetch_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Driver: upload write with model update.
    task automatic wr(input logic [7:0] code, input logic [7:0] data,
                      input logic [15:0] afield);
        reg_wr = 1'b1;
        reg_wdata = {code, data, afield};
        @(negedge clk);
        reg_wr = 1'b0;
        m_code = code;
        if (code == 8'h0F) begin
            m_ptr = {m_ptr[AW-1:8], afield[7:0]};
            m_mem[m_ptr] = data;
        end
    endtask

    // Driver: read strobe, expected word pushed to the scoreboard.
    task automatic rd(input string tag);
        exp_q.push_back({m_code, m_mem[m_ptr], {(16-AW){1'b0}}, m_ptr});
        tag_q.push_back(tag);
        if (m_code == 8'h0F) m_ptr = m_ptr + 1'b1;
        reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    always @(posedge clk) rd_seen <= rst_n && reg_rd && !reg_wr;

    // Monitor: compare each read result one cycle after its strobe.
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) chk(1'b0, "R4 unexpected read", reg_rdata, 32'h0);
            else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(reg_rdata === e, t, reg_rdata, e);
            end
        end
    end

    task automatic finish_run;
        chk(exp_q.size() == 0, "R4 queue drained", exp_q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cpu_hold === 1'b1, "R1 hold after reset", cpu_hold, 1);
        chk(reg_rdata === 32'h0, "R1 rdata after reset", reg_rdata, 0);

        // R2 enter upload, code reported on read
        wr(8'h0F, 8'h00, 16'h0000);
        chk(cpu_hold === 1'b1, "R2 hold in upload", cpu_hold, 1);
        chk(fetch_data === 8'h00, "R8 fetch zero while held", fetch_data, 0);
        rd("R2 code 0F on read");

        // R3 R5 fill every location with write and confirm-read pairs
        for (int i = 0; i < DEPTH; i++) begin
            wr(8'h0F, 8'((i * 37 + 11) ^ (i >> 8)), 16'(i & 8'hFF));
            rd("R5 readback equals written word");
        end

        // R4 walk the whole image from the wrapped pointer
        chk(m_ptr == 0, "R4 pointer wrapped", m_ptr, 0);
        for (int i = 0; i < DEPTH; i++) rd("R4 verify pass");

        // R3 upper address bits of the write are ignored
        for (int i = 0; i < 3 * 256 + 4; i++) rd("R4 step to page 3");
        wr(8'h0F, 8'hA5, 16'h0A42);
        rd("R3 page from pointer not host");

        // R9 simultaneous write and read: read dropped
        held = reg_rdata;
        reg_rd = 1'b1;
        wr(8'h0F, 8'h5A, 16'h0077);
        reg_rd = 1'b0;
        @(negedge clk);
        chk(reg_rdata === held, "R9 read dropped", reg_rdata, held);
        rd("R9 write taken");

        // R6 close: no store, pointer frozen
        wr(8'h03, 8'h00, 16'h1000);
        chk(cpu_hold === 1'b1, "R6 hold after close", cpu_hold, 1);
        wr(8'h03, 8'hEE, 16'h0010);
        rd("R6 read after close");
        rd("R6 pointer frozen");

        // R7 release and R8 fetch
        wr(8'h13, 8'h00, 16'h0000);
        chk(cpu_hold === 1'b0, "R7 running", cpu_hold, 0);
        for (int k = 0; k < 6; k++) begin
            fetch_addr = AW'(k * 700 + 16);
            @(negedge clk);
            chk(fetch_data === m_mem[fetch_addr], "R8 fetch data", fetch_data,
                m_mem[fetch_addr]);
        end
        fetch_addr = AW'(12'h310);
        @(negedge clk);
        chk(fetch_data === m_mem[12'h310], "R6 closed write not stored",
            fetch_data, m_mem[12'h310]);

        // R7 any other code holds again
        wr(8'h03, 8'h00, 16'h0000);
        chk(cpu_hold === 1'b1, "R7 hold on other code", cpu_hold, 1);
        @(negedge clk);
        chk(fetch_data === 8'h00, "R8 fetch zero after hold", fetch_data, 0);
        @(negedge clk);
        finish_run();
    end
endmodule